// File: doc/BRIEF.md
# RS-485 Driver Direction Controller

This block drives the direction pin of a half-duplex RS-485 transceiver on behalf of a UART transmitter. The pin turns the line driver on while the transmitter has data to send. After the last stop bit has left the serializer, the pin stays on for a programmable turnaround hold before the driver lets go of the bus. The hold is counted in baud ticks and can be any value from 0 to 255 bit times. This gives the far end's line and the local receiver time to settle before another node may drive the bus.

The transmitter reports two things. It raises `tx_pending` while its FIFO holds data or its shift register is busy. It pulses `stop_done` for one cycle when the final stop bit completes. The controller also takes the baud-rate tick, a software force bit, a polarity select bit and the 8-bit hold length. The force bit takes precedence over everything else and keeps the driver on. The polarity bit decides whether "driver on" is a high or a low level on the pin.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset the driver is off, so the pin shows the released level. That level is 1 when `invert` = 0 and 0 when `invert` = 1.
- R2: When `tx_pending` is seen high at a clock edge, the pin shows the asserted level from that edge on.
- R3: With `hold_len` = 0, a `stop_done` pulse while `tx_pending` is low releases the pin at the clock edge that samples the pulse.
- R4: With `hold_len` = N > 0, the pin stays asserted after the `stop_done` pulse until the N-th `baud_tick` that follows it. The pin is released at that tick's clock edge. A tick in the same cycle as the pulse is not counted.
- R5: The hold count changes only on `baud_tick` cycles. Cycles without a tick do not advance the release.
- R6: If `tx_pending` rises while a hold is running, the hold is cancelled and the pin stays asserted. The next `stop_done` starts a full hold of `hold_len` ticks.
- R7: A `stop_done` pulse while `tx_pending` is still high leaves the pin asserted and starts no hold.
- R8: Pin levels: asserted = 0 and released = 1 when `invert` = 0; asserted = 1 and released = 0 when `invert` = 1. A change of `invert` takes effect on the pin at once.
- R9: While `force_on` is high, the pin shows the asserted level from the edge after it is seen, whatever the other inputs do. When `force_on` falls, the pin returns to the level set by the other controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_pending | input | 1 | Transmit data waiting or shifting |
| stop_done | input | 1 | One-cycle strobe at the end of the last stop bit |
| baud_tick | input | 1 | One-cycle enable per bit time |
| force_on | input | 1 | Software override, keeps the driver on |
| invert | input | 1 | Pin polarity select |
| hold_len | input | 8 | Turnaround hold in bit times |
| dir_pin | output | 1 | Transceiver direction pin |

## Verification
The bench runs release timing for holds of 0, 1 and 255 bit times under both polarities. It leaves idle cycles between ticks, so a counter that ran on the system clock would release early. An off-by-one in the load or the expiry would release one tick early or late, and the tick-by-tick checks see either. A new transmission during the hold must cancel the hold and re-arm the full length, where a broken design would drop the driver in mid-frame. The force bit is held across a hold expiry, which shows whether the override really wins.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_SEND = 2'd1,
        DIR_HOLD = 2'd2
    } dir_state_e;

    typedef struct packed {
        dir_state_e state;
    } dir_fsm_regs_t;

    typedef struct packed {
        logic on;
    } dir_out_regs_t;

endpackage

// File: rtl/rs485_hold_timer.sv
module rs485_hold_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clear_i,
    input  logic             tick_i,
    output logic             expire_o,
    output logic             busy_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_regs_t;

    timer_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.cnt = '0;
        end else if (load_i) begin
            r_d.cnt = load_val_i;
        end else if (tick_i && (r_q.cnt != '0)) begin
            r_d.cnt = r_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign expire_o = tick_i && (r_q.cnt == ONE) && !load_i && !clear_i;
    assign busy_o   = (r_q.cnt != '0);

    // R5: the count holds still on cycles without a tick, load or clear
    assert_count_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i && !clear_i) |=> $stable(r_q.cnt));

    // R5: a tick on a running count removes exactly one bit time
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && !clear_i && busy_o) |=> (r_q.cnt == $past(r_q.cnt) - ONE));

endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
    import rs485_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_pending_i,
    input  logic       stop_done_i,
    input  logic       hold_zero_i,
    input  logic       expire_i,
    output logic       load_o,
    output logic       clear_o,
    output logic       drive_d_o,
    output dir_state_e state_o
);

    dir_fsm_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        load_o  = 1'b0;
        clear_o = 1'b0;
        unique case (r_q.state)
            DIR_IDLE: begin
                if (tx_pending_i) r_d.state = DIR_SEND;
            end
            DIR_SEND: begin
                if (stop_done_i && !tx_pending_i) begin
                    if (hold_zero_i) begin
                        r_d.state = DIR_IDLE;
                    end else begin
                        load_o    = 1'b1;
                        r_d.state = DIR_HOLD;
                    end
                end
            end
            DIR_HOLD: begin
                if (tx_pending_i) begin
                    clear_o   = 1'b1;
                    r_d.state = DIR_SEND;
                end else if (expire_i) begin
                    r_d.state = DIR_IDLE;
                end
            end
            default: r_d.state = DIR_IDLE;
        endcase
        drive_d_o = (r_d.state != DIR_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.state <= DIR_IDLE;
        else        r_q       <= r_d;
    end

    assign state_o = r_q.state;

    // R7: sending ends only through a stop strobe
    assert_send_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == DIR_SEND && !stop_done_i) |=> (r_q.state == DIR_SEND));

    // R6: new data during a hold always returns to sending
    assert_hold_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == DIR_HOLD && tx_pending_i) |=> (r_q.state == DIR_SEND));

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_pending,
    input  logic              stop_done,
    input  logic              baud_tick,
    input  logic              force_on,
    input  logic              invert,
    input  logic [HOLD_W-1:0] hold_len,
    output logic              dir_pin
);

    logic       load, clear, expire, busy, fsm_drive_d;
    dir_state_e state;

    rs485_hold_timer #(.CNT_W(HOLD_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (hold_len),
        .clear_i    (clear),
        .tick_i     (baud_tick),
        .expire_o   (expire),
        .busy_o     (busy)
    );

    rs485_dir_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_pending_i (tx_pending),
        .stop_done_i  (stop_done),
        .hold_zero_i  (hold_len == '0),
        .expire_i     (expire),
        .load_o       (load),
        .clear_o      (clear),
        .drive_d_o    (fsm_drive_d),
        .state_o      (state)
    );

    dir_out_regs_t o_q, o_d;

    always_comb begin
        o_d    = o_q;
        o_d.on = force_on || fsm_drive_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    // asserted level follows invert: high when set, low when clear
    assign dir_pin = invert ? o_q.on : !o_q.on;

    // R9: the override wins over every other control
    assert_force_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_on |=> o_q.on);

    // R2: pending data turns the driver on at the next edge
    assert_pending_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pending |=> o_q.on);

    // R4: a hold in progress always has bit times left on the timer
    assert_hold_has_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DIR_HOLD) |-> busy);

    // R3: a zero hold leaves the driver off right after the strobe
    assert_zero_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DIR_SEND && stop_done && !tx_pending && hold_len == '0 && !force_on)
        |=> !o_q.on);

endmodule

// File: tb/tb_rs485_dir_ctrl.sv
module tb_rs485_dir_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_pending, stop_done, baud_tick, force_on, invert;
    logic [7:0] hold_len;
    logic       dir_pin;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rs485_dir_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tx_pending(tx_pending), .stop_done(stop_done),
        .baud_tick(baud_tick), .force_on(force_on), .invert(invert),
        .hold_len(hold_len), .dir_pin(dir_pin)
    );

    function automatic logic lvl(input logic on);
        return invert ? on : !on;
    endfunction

    task automatic check(input logic on, input string tag);
        checks++;
        if (dir_pin !== lvl(on)) begin
            errors++;
            $display("FAIL %s: dir_pin=%b expected %b (invert=%b)", tag, dir_pin, lvl(on), invert);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_stop();
        stop_done = 1'b1; cyc(1); stop_done = 1'b0;
    endtask

    task automatic pulse_tick();
        baud_tick = 1'b1; cyc(1); baud_tick = 1'b0;
    endtask

    task automatic start_frame();
        tx_pending = 1'b1; cyc(1);
        check(1'b1, "R2 pending asserts");
        cyc(3);
        tx_pending = 1'b0; cyc(2);
        check(1'b1, "R2 held while shifting");
    endtask

    task automatic t_reset();
        rst_n = 1'b0; invert = 1'b0; cyc(3); rst_n = 1'b1; cyc(1);
        check(1'b0, "R1 reset released inv0");
        invert = 1'b1; #1;
        check(1'b0, "R8 released inv1");
        invert = 1'b0; #1;
        check(1'b0, "R8 released inv0");
    endtask

    task automatic t_delay(input int n, input logic inv);
        invert = inv; hold_len = 8'(n);
        start_frame();
        pulse_stop();
        if (n == 0) begin
            check(1'b0, "R3 zero hold release");
        end else begin
            check(1'b1, "R4 asserted after stop");
            for (int k = 1; k <= n; k++) begin
                cyc(1);
                check(1'b1, "R5 no tick no release");
                pulse_tick();
                if (k < n) check(1'b1, "R4 hold running");
                else       check(1'b0, "R4 released on last tick");
            end
        end
        cyc(2);
        check(1'b0, "R4 stays released");
    endtask

    task automatic t_cancel();
        invert = 1'b0; hold_len = 8'd5;
        start_frame();
        pulse_stop();
        pulse_tick(); pulse_tick();
        tx_pending = 1'b1; cyc(1); tx_pending = 1'b0;
        for (int k = 0; k < 6; k++) pulse_tick();
        check(1'b1, "R6 hold cancelled by new data");
        pulse_stop();
        for (int k = 0; k < 4; k++) pulse_tick();
        check(1'b1, "R6 full hold restarted");
        pulse_tick();
        check(1'b0, "R6 released after full hold");
    endtask

    task automatic t_stop_pending();
        invert = 1'b1; hold_len = 8'd0;
        tx_pending = 1'b1; cyc(1);
        pulse_stop();
        check(1'b1, "R7 stop while pending");
        tx_pending = 1'b0; cyc(2);
        check(1'b1, "R7 still sending");
        pulse_stop();
        check(1'b0, "R7 later stop releases");
    endtask

    task automatic t_force(input logic inv);
        invert = inv; hold_len = 8'd1;
        force_on = 1'b1; cyc(1);
        check(1'b1, "R9 force from idle");
        start_frame();
        pulse_stop(); pulse_tick(); cyc(2);
        check(1'b1, "R9 force over hold expiry");
        force_on = 1'b0; cyc(1);
        check(1'b0, "R9 release after force drop");
    endtask

    initial begin
        rst_n = 1'b0; tx_pending = 1'b0; stop_done = 1'b0; baud_tick = 1'b0;
        force_on = 1'b0; invert = 1'b0; hold_len = 8'd0;
        cyc(1);
        t_reset();
        t_delay(0, 1'b0);
        t_delay(0, 1'b1);
        t_delay(1, 1'b0);
        t_delay(1, 1'b1);
        t_delay(255, 1'b0);
        t_delay(255, 1'b1);
        t_cancel();
        t_stop_pending();
        t_force(1'b0);
        t_force(1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule